// File: doc/BRIEF.md
# Serial Peripheral Slave with a Shared Shift/Data Register

This block is the slave end of a mode-0 serial peripheral link. An external master drives the serial clock, the data-in line and an active-low select. The slave shifts bytes most significant bit first. A single register does two jobs: it holds the byte being sent and it gathers the byte being received. The three link pins are brought into the system clock domain through synchronizer chains. All shifting happens on edges detected in that domain, so the system clock must run at least four times faster than the serial clock.

The host sees four things:
- A write port that loads the shared register directly, with nothing buffered in between. A write made while a byte is in flight changes only the bits that have not yet left.
- A receive holding register. It captures each completed byte, and the host can read it while the next byte arrives.
- A completion flag with a gated interrupt.
- The synchronized level of the select line.

If the host writes nothing between bytes, the byte just received stays in the shared register and is sent back during the next transfer.

Top module: `spi_shared_slave`

## Requirements
- R1: After reset, the holding register is 0x00, the completion flag and the interrupt are low, and the output enable is low. A first transfer with no host write sends 0x00 on the data-out line.
- R2: While select is low, the bit on the data-in line at each rising serial clock edge is taken MSB first. After the eighth rising edge the assembled byte appears in the holding register.
- R3: A host write made while no bits of the current byte have been shifted is sent out whole, MSB first. The data-out line advances to the next bit only after a falling serial clock edge.
- R4: If the host does not write between two bytes, the next transfer sends the byte received in the previous one.
- R5: A host write made after k falling edges of a byte replaces only the bits that have not yet been sent. The bits sent at bit positions 7-k down to 0 come from the new value. The bits at positions 7 down to 8-k keep the old value.
- R6: The holding register changes only when a byte completes. If the host does not read it, the next completed byte overwrites it.
- R7: The completion flag sets at the end of every full 8-bit transfer. The interrupt output equals the flag ANDed with the interrupt enable input.
- R8: The flag clears only when a status read is seen while the flag is set, followed later by a data read or a data write. A data access without that earlier status read leaves the flag set.
- R9: If select goes high before the eighth rising edge, the partial byte is dropped. No flag is set and the holding register is unchanged. The next byte is counted from its first bit.
- R10: The data-out enable is low whenever the synchronized select is high, and high while it is low.
- R11: The select status output follows the level of the select pin after synchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_sel_n | input | 1 | Active-low slave select |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Enable for the external data-out pad driver |
| host_wr | input | 1 | Host write strobe for the shared register |
| host_wdata | input | DW | Host write data |
| host_data_rd | input | 1 | Host read strobe for the holding register |
| host_stat_rd | input | 1 | Host read strobe for the status |
| irq_en | input | 1 | Interrupt enable |
| rx_hold | output | DW | Receive holding register |
| stat_done | output | 1 | Transfer-complete flag |
| stat_sel_n | output | 1 | Synchronized select level |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default byte width of eight and a two-stage synchronizer. The master half-period is ten system clocks, so each serial edge has settled in the shift logic before the next one arrives. With that margin, a host write can be placed inside any of the eight low phases of a byte. This lets randomized transfers cover every partial-replacement position, as well as whole-byte loads and echo of the received byte. Directed cases cover overrun of the holding register, the two-step flag clear, a masked interrupt and a byte aborted after three bits.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  // Link pins as seen by the synchronizer chain.
  typedef struct packed {
    logic sel_n;
    logic mosi;
    logic sck;
  } link_pins_t;

  localparam int LINK_W = $bits(link_pins_t);
  // Reset value: deselected, clock low, data low.
  localparam link_pins_t LINK_IDLE = '{sel_n: 1'b1, mosi: 1'b0, sck: 1'b0};
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int W       = 3,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_n;

  always_comb begin
    chain_n[0] = d;
    for (int s = 1; s < STAGES; s++) chain_n[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_n;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_s,
  input  logic          mosi_s,
  input  logic          desel_s,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          tx_bit,
  output logic [DW-1:0] hold,
  output logic          done
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sck_d;
  logic [DW-1:0] sr_q,  sr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cap_vld_q, cap_vld_n;
  logic          cap_bit_q, cap_bit_n;
  logic [DW-1:0] hold_q, hold_n;
  logic          done_q, done_n;
  logic          rise, fall;
  logic [CW-1:0] sent;

  assign rise = sck_s & ~sck_d;
  assign fall = ~sck_s & sck_d;

  always_comb begin
    sr_n      = sr_q;
    cnt_n     = cnt_q;
    cap_vld_n = cap_vld_q;
    cap_bit_n = cap_bit_q;
    hold_n    = hold_q;
    done_n    = 1'b0;
    if (desel_s) begin
      cnt_n     = '0;
      cap_vld_n = 1'b0;
    end else if (rise) begin
      if (cnt_q == LAST) begin
        hold_n    = {sr_q[DW-2:0], mosi_s};
        sr_n      = {sr_q[DW-2:0], mosi_s};
        cnt_n     = '0;
        cap_vld_n = 1'b0;
        done_n    = 1'b1;
      end else begin
        cnt_n     = cnt_q + 1'b1;
        cap_vld_n = 1'b1;
        cap_bit_n = mosi_s;
      end
    end else if (fall && cap_vld_q) begin
      sr_n      = {sr_q[DW-2:0], cap_bit_q};
      cap_vld_n = 1'b0;
    end
    // Unbuffered load: bits already shifted keep their received content.
    sent = cnt_n - CW'(cap_vld_n);
    if (wr_en)
      sr_n = (wr_data << sent) | (sr_n & ((DW'(1) << sent) - DW'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d     <= 1'b0;
      sr_q      <= '0;
      cnt_q     <= '0;
      cap_vld_q <= 1'b0;
      cap_bit_q <= 1'b0;
      hold_q    <= '0;
      done_q    <= 1'b0;
    end else begin
      sck_d     <= sck_s;
      sr_q      <= sr_n;
      cnt_q     <= cnt_n;
      cap_vld_q <= cap_vld_n;
      cap_bit_q <= cap_bit_n;
      hold_q    <= hold_n;
      done_q    <= done_n;
    end
  end

  assign tx_bit = sr_q[DW-1];
  assign hold   = hold_q;
  assign done   = done_q;

  // R6: holding register moves only together with a completion
  p_hold_only_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(hold_q));
  // R9: no completion may follow a cycle with select released
  p_no_done_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    desel_s |=> !done_q);
  // R9: bit counter restarts whenever select is released
  p_cnt_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    desel_s |=> (cnt_q == '0));
endmodule

// File: rtl/spi_slv_flag.sv
module spi_slv_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic stat_rd,
  input  logic data_acc,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_n;
  logic arm_q,  arm_n;

  always_comb begin
    flag_n = flag_q;
    arm_n  = arm_q;
    if (stat_rd && flag_q) arm_n = 1'b1;
    if (data_acc && arm_q) begin
      flag_n = 1'b0;
      arm_n  = 1'b0;
    end
    if (done) flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      arm_q  <= arm_n;
    end
  end

  assign flag = flag_q;
  assign irq  = flag_q & irq_en;

  // R7: a completion always raises the flag on the next cycle
  p_flag_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q);
  // R8: flag falls only after an armed data access
  p_clear_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> ($past(arm_q) && $past(data_acc)));
endmodule

// File: rtl/spi_shared_slave.sv
module spi_shared_slave #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  input  logic          spi_sel_n,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_data_rd,
  input  logic          host_stat_rd,
  input  logic          irq_en,
  output logic [DW-1:0] rx_hold,
  output logic          stat_done,
  output logic          stat_sel_n,
  output logic          irq
);
  import spi_slv_pkg::*;

  link_pins_t pins_raw, pins_s;
  logic       tx_bit;
  logic       done;

  assign pins_raw = '{sel_n: spi_sel_n, mosi: spi_mosi, sck: spi_sck};

  spi_slv_sync #(
    .W(LINK_W), .STAGES(SYNC_STAGES), .RST_VAL(LINK_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  spi_slv_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .sck_s(pins_s.sck), .mosi_s(pins_s.mosi), .desel_s(pins_s.sel_n),
    .wr_en(host_wr), .wr_data(host_wdata),
    .tx_bit(tx_bit), .hold(rx_hold), .done(done)
  );

  spi_slv_flag u_flag (
    .clk(clk), .rst_n(rst_n), .done(done),
    .stat_rd(host_stat_rd), .data_acc(host_data_rd | host_wr),
    .irq_en(irq_en), .flag(stat_done), .irq(irq)
  );

  assign spi_miso_oe = ~pins_s.sel_n;
  assign spi_miso    = tx_bit & ~pins_s.sel_n;
  assign stat_sel_n  = pins_s.sel_n;

  // R10: output enable tracks the select status seen by the host
  p_oe_vs_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso_oe != stat_sel_n);
  // R7: interrupt never asserts without the flag
  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_done);
endmodule

// File: tb/sim_spi_shared_slave.sv
module sim_spi_shared_slave;
  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       spi_sck, spi_mosi, spi_sel_n;
  logic       spi_miso, spi_miso_oe;
  logic       host_wr, host_data_rd, host_stat_rd, irq_en;
  logic [7:0] host_wdata;
  logic [7:0] rx_hold;
  logic       stat_done, stat_sel_n, irq;

  int nchk  = 0;
  int nfail = 0;
  logic [7:0] exp_sr;
  logic [7:0] exp_hold;

  always #2.5 clk = ~clk;

  spi_shared_slave u0 (
    .clk(clk), .rst_n(rst_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_sel_n(spi_sel_n),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .host_wr(host_wr), .host_wdata(host_wdata),
    .host_data_rd(host_data_rd), .host_stat_rd(host_stat_rd),
    .irq_en(irq_en), .rx_hold(rx_hold), .stat_done(stat_done),
    .stat_sel_n(stat_sel_n), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected output when k bits went out before a write of w over old.
  function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] w, input int k);
    logic [7:0] low;
    low = 8'((9'd1 << (8 - k)) - 9'd1);
    return (old & ~low) | (w & low);
  endfunction

  task automatic pulse_wr(input logic [7:0] v);
    host_wr = 1'b1; host_wdata = v; @(negedge clk); host_wr = 1'b0;
  endtask
  task automatic pulse_stat;
    host_stat_rd = 1'b1; @(negedge clk); host_stat_rd = 1'b0;
  endtask
  task automatic pulse_drd;
    host_data_rd = 1'b1; @(negedge clk); host_data_rd = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] m, input int nbits, input int wk,
                      input logic [7:0] wv, output logic [7:0] got);
    got = '0;
    spi_sel_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(spi_miso_oe == 1'b1, "R10 oe while selected", 32'(spi_miso_oe), 1);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = m[7-i];
      if (i == wk) begin
        repeat (5) @(negedge clk);
        pulse_wr(wv);
        repeat (HALF - 6) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      if (i == 4) chk(rx_hold == exp_hold, "R6 hold stable mid-byte", 32'(rx_hold), 32'(exp_hold));
      got[7-i] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_sel_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic run(input logic [7:0] m, input int wk, input logic [7:0] wv,
                     input bit clr, input string txreq);
    logic [7:0] got, exp_tx;
    exp_tx = (wk >= 0) ? merge(exp_sr, wv, wk) : exp_sr;
    xfer(m, 8, wk, wv, got);
    chk(got == exp_tx, txreq, 32'(got), 32'(exp_tx));
    chk(rx_hold == m, "R2 received byte in hold", 32'(rx_hold), 32'(m));
    chk(stat_done == 1'b1, "R7 flag after byte", 32'(stat_done), 1);
    chk(irq == irq_en, "R7 irq gating", 32'(irq), 32'(irq_en));
    exp_sr   = m;
    exp_hold = m;
    if (clr) begin
      pulse_stat;
      pulse_drd;
      chk(stat_done == 1'b0, "R8 flag cleared by status then data read", 32'(stat_done), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] got;
    void'($urandom(32'h1234_abcd));
    rst_n = 1'b0;
    spi_sck = 1'b0; spi_mosi = 1'b0; spi_sel_n = 1'b1;
    host_wr = 1'b0; host_wdata = '0; host_data_rd = 1'b0; host_stat_rd = 1'b0;
    irq_en = 1'b1;
    exp_sr = '0; exp_hold = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(rx_hold == 8'h00, "R1 hold reset", 32'(rx_hold), 0);
    chk(stat_done == 1'b0, "R1 flag reset", 32'(stat_done), 0);
    chk(irq == 1'b0, "R1 irq reset", 32'(irq), 0);
    chk(spi_miso_oe == 1'b0, "R10 oe off when deselected", 32'(spi_miso_oe), 0);
    chk(stat_sel_n == 1'b1, "R11 select status high", 32'(stat_sel_n), 1);

    // R11 select level visible, no clock edges
    spi_sel_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(stat_sel_n == 1'b0, "R11 select status low", 32'(stat_sel_n), 0);
    spi_sel_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(stat_sel_n == 1'b1, "R11 select status back high", 32'(stat_sel_n), 1);
    chk(spi_miso_oe == 1'b0, "R10 oe off again", 32'(spi_miso_oe), 0);

    run(8'hA5, -1, 8'h00, 1'b1, "R1 first byte sends zero");
    run(8'h3C, -1, 8'h00, 1'b1, "R4 echo of previous byte");
    run(8'h81, 0, 8'hC3, 1'b1, "R3 whole written byte sent");
    run(8'h5E, 3, 8'h0F, 1'b1, "R5 write after three bits");

    // R6 overrun: second byte overwrites unread first
    run(8'h11, -1, 8'h00, 1'b0, "R4 echo before overrun");
    run(8'h22, -1, 8'h00, 1'b0, "R4 echo during overrun");
    chk(rx_hold == 8'h22, "R6 unread byte overwritten", 32'(rx_hold), 32'h22);

    // R8 data access alone does not clear
    pulse_drd;
    chk(stat_done == 1'b1, "R8 data read without status read", 32'(stat_done), 1);
    pulse_stat;
    pulse_wr(8'h00);
    exp_sr = 8'h00;
    chk(stat_done == 1'b0, "R8 status read then data write", 32'(stat_done), 0);

    // R7 masked interrupt
    irq_en = 1'b0;
    run(8'h6B, -1, 8'h00, 1'b0, "R4 echo of written zero");
    chk(irq == 1'b0 && stat_done == 1'b1, "R7 irq masked with flag set", 32'(irq), 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R7 irq on enable", 32'(irq), 1);
    pulse_stat; pulse_drd;

    // R9 abort after three bits
    xfer(8'hFF, 3, -1, 8'h00, got);
    chk(stat_done == 1'b0, "R9 no flag on aborted byte", 32'(stat_done), 0);
    chk(rx_hold == 8'h6B, "R9 hold untouched by abort", 32'(rx_hold), 32'h6B);
    pulse_wr(8'h5A);
    exp_sr = 8'h5A;
    run(8'h96, -1, 8'h00, 1'b1, "R9 full byte after abort");

    // Randomized transfers across all write positions
    for (int n = 0; n < 40; n++) begin
      logic [7:0] m, wv;
      int wk;
      m  = 8'($urandom);
      wv = 8'($urandom);
      wk = int'($urandom % 9) - 1;
      run(m, wk, wv, 1'b1, (wk < 0) ? "R4 random echo" : "R5 random write position");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule